// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block picks which pending interrupt line, if any, should go to the processor. It takes a request vector, a mask vector and an in-service vector, all one bit per line. It also takes a rotation offset that sets where the priority order starts, two mode flags and a strap that marks the instance as the primary controller in a cascaded pair. From these it produces a valid flag and the number of the winning line, both combinational. It also drives a registered interrupt pin.

Priority is counted from the offset. Line `(offset + k) mod N` has rank `k`, and rank 0 is the most urgent. A candidate is a line that is requested and not masked. The best candidate is presented only when its rank is strictly better than the best rank still in service. Two modes adjust which in-service bits take part in that comparison. In special-mask mode, masked lines are dropped. In nested-exclusion mode on the primary instance, the cascade line is dropped.

Top module: `prio_resolver`

## Requirements
- R1: While `rst_n` is low, and at the first sampling after it rises, `int_out` is 0.
- R2: With N=8, line `(rot_ofs + k) mod 8` has rank k. Of the candidates, the one with the smallest rank wins. For example, requests on lines 0 and 7 with `rot_ofs`=3 select line 7.
- R3: Candidates are `req_vec & ~mask_vec`. When no candidate remains, `win_valid` is 0.
- R4: An in-service line blocks every candidate whose rank is equal to or worse than its own. A candidate with a strictly better rank still wins. With an empty in-service set, any candidate wins.
- R5: When `masked_svc_en` is 1, in-service bits on masked lines are ignored in the comparison. When it is 0, they block as in R4.
- R6: When `nest_excl_en` and `is_primary` are both 1, in-service bit 2 (the cascade line) is ignored in the comparison. If either flag is 0, that bit blocks as in R4.
- R7: `win_line` equals (winning rank + `rot_ofs`) mod 8 when `win_valid` is 1, and equals 0 when `win_valid` is 0.
- R8: `int_out` equals the value `win_valid` had at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vec | input | 8 | Pending requests, one bit per line |
| mask_vec | input | 8 | Line masks; 1 blocks the line |
| svc_vec | input | 8 | Lines currently in service |
| rot_ofs | input | 3 | Line that holds rank 0 |
| masked_svc_en | input | 1 | Ignore in-service bits of masked lines |
| nest_excl_en | input | 1 | Ignore the cascade in-service bit on the primary |
| is_primary | input | 1 | Strap: 1 for the primary controller |
| win_valid | output | 1 | A line should be presented |
| win_line | output | 3 | Winning line number |
| int_out | output | 1 | Registered interrupt pin |

## Verification
`win_valid` and `win_line` depend only on the present inputs, so they are due in the same cycle as the stimulus. The bench drives each vector on the falling edge and checks both outputs one time unit later, before the next rising edge. `int_out` is due one rising edge later. The bench checks it at the following falling edge against the expected validity of the vector applied before that edge, and only then applies the next vector.

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int N = 8,
  parameter int CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_vec,
  input  logic [N-1:0]         mask_vec,
  input  logic [N-1:0]         svc_vec,
  input  logic [$clog2(N)-1:0] rot_ofs,
  input  logic                 masked_svc_en,
  input  logic                 nest_excl_en,
  input  logic                 is_primary,
  output logic                 win_valid,
  output logic [$clog2(N)-1:0] win_line,
  output logic                 int_out
);
  localparam int W = $clog2(N);
  localparam logic [W:0] NONE = (W+1)'(N);
  localparam logic [N-1:0] CAS_BIT = N'(1) << CASCADE_LINE;

  function automatic logic [W:0] rank(input logic [N-1:0] v, input logic [W-1:0] ofs);
    rank = NONE;
    for (int k = N - 1; k >= 0; k--)
      if (v[(int'(ofs) + k) % N]) rank = (W+1)'(k);
  endfunction

  logic [N-1:0] cand, svc_eff;
  logic [W:0]   req_rank, cur_rank;
  logic [W-1:0] line_sum;

  assign cand     = req_vec & ~mask_vec;
  assign svc_eff  = svc_vec & ~(masked_svc_en ? mask_vec : '0)
                            & ~((nest_excl_en && is_primary) ? CAS_BIT : '0);
  assign req_rank = rank(cand, rot_ofs);
  assign cur_rank = rank(svc_eff, rot_ofs);
  assign line_sum = req_rank[W-1:0] + rot_ofs;
  assign win_valid = req_rank < cur_rank;
  assign win_line  = win_valid ? line_sum : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) int_out <= 1'b0;
    else        int_out <= win_valid;

  AST_PIN_LAGS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int_out == $past(win_valid)); // R8
  AST_NO_CAND_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_vec & ~mask_vec) == '0) |-> !win_valid); // R3
  AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (req_vec[win_line] && !mask_vec[win_line])); // R2
  AST_WIN_NOT_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !(nest_excl_en && is_primary && win_line == W'(CASCADE_LINE)))
      |-> !svc_vec[win_line]); // R4
  AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> win_line == '0); // R7
endmodule

// File: tb/prio_resolver_tb.sv
module prio_resolver_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] req_vec = 0, mask_vec = 0, svc_vec = 0;
  logic [2:0] rot_ofs = 0;
  logic masked_svc_en = 0, nest_excl_en = 0, is_primary = 0;
  logic win_valid, int_out;
  logic [2:0] win_line;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_resolver u_dut (.clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
    .svc_vec(svc_vec), .rot_ofs(rot_ofs), .masked_svc_en(masked_svc_en),
    .nest_excl_en(nest_excl_en), .is_primary(is_primary),
    .win_valid(win_valid), .win_line(win_line), .int_out(int_out));

  function automatic void model(output logic v, output logic [2:0] ln);
    logic [7:0] c = req_vec & ~mask_vec;
    logic [7:0] s = svc_vec;
    int best = 8, cur = 8;
    if (masked_svc_en) s = s & ~mask_vec;
    if (nest_excl_en && is_primary) s[2] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (best == 8 && c[(rot_ofs + k) % 8]) best = k;
      if (cur == 8 && s[(rot_ofs + k) % 8]) cur = k;
    end
    v = best < cur;
    ln = v ? 3'((best + rot_ofs) % 8) : 3'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [7:0] r, input logic [7:0] m,
                       input logic [7:0] s, input logic [2:0] o,
                       input logic sm, input logic ne, input logic pr);
    logic ev; logic [2:0] el;
    @(negedge clk);
    req_vec = r; mask_vec = m; svc_vec = s; rot_ofs = o;
    masked_svc_en = sm; nest_excl_en = ne; is_primary = pr;
    #1;
    model(ev, el);
    check({tag, " valid"}, {7'd0, win_valid}, {7'd0, ev});
    check({tag, " line R7"}, {5'd0, win_line}, {5'd0, el});
    @(negedge clk);
    check("R8 int_out", {7'd0, int_out}, {7'd0, ev});
  endtask

  task automatic expect_line(input string tag, input logic v, input logic [2:0] ln);
    check({tag, " fixed valid"}, {7'd0, win_valid}, {7'd0, v});
    check({tag, " fixed line"}, {5'd0, win_line}, {5'd0, ln});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    req_vec = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 int_out in reset", {7'd0, int_out}, 8'd0);
    rst_n = 1;
    req_vec = 8'h00;
    #1 check("R1 int_out after reset", {7'd0, int_out}, 8'd0);
    @(negedge clk);
    check("R1 int_out first cycle", {7'd0, int_out}, 8'd0);

    apply("R2 rot3", 8'h81, 0, 0, 3, 0, 0, 0);           expect_line("R2 rot3", 1, 7);
    apply("R2 rot0", 8'h81, 0, 0, 0, 0, 0, 0);           expect_line("R2 rot0", 1, 0);
    apply("R2 rot7 wrap", 8'h41, 0, 0, 7, 0, 0, 0);      expect_line("R2 rot7", 1, 0);
    apply("R3 empty", 8'h00, 0, 0, 0, 0, 0, 0);          expect_line("R3 empty", 0, 0);
    apply("R3 all masked", 8'h3C, 8'h3C, 0, 0, 0, 0, 0); expect_line("R3 masked", 0, 0);
    apply("R3 partial mask", 8'h3C, 8'h0C, 0, 0, 0, 0, 0); expect_line("R3 partial", 1, 4);
    apply("R4 equal blocked", 8'h10, 0, 8'h10, 0, 0, 0, 0); expect_line("R4 equal", 0, 0);
    apply("R4 lower blocked", 8'h20, 0, 8'h10, 0, 0, 0, 0); expect_line("R4 lower", 0, 0);
    apply("R4 higher wins", 8'h08, 0, 8'h10, 0, 0, 0, 0);  expect_line("R4 higher", 1, 3);
    apply("R5 off blocks", 8'h20, 8'h04, 8'h04, 0, 0, 0, 0); expect_line("R5 off", 0, 0);
    apply("R5 on ignores", 8'h20, 8'h04, 8'h04, 0, 1, 0, 0); expect_line("R5 on", 1, 5);
    apply("R6 primary excl", 8'h40, 0, 8'h04, 0, 0, 1, 1); expect_line("R6 prim", 1, 6);
    apply("R6 secondary", 8'h40, 0, 8'h04, 0, 0, 1, 0);   expect_line("R6 sec", 0, 0);
    apply("R6 mode off", 8'h40, 0, 8'h04, 0, 0, 0, 1);    expect_line("R6 off", 0, 0);
    apply("R6 cascade req", 8'h04, 0, 8'h04, 0, 0, 1, 1); expect_line("R6 self", 1, 2);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r, m, s;
      r = 8'($urandom); m = 8'($urandom) & 8'($urandom);
      s = 8'($urandom) & 8'($urandom) & 8'($urandom);
      apply("R2 R4 R5 R6 random", r, m, s, 3'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule